// File: doc/BRIEF.md
# Prioritized vectored interrupt controller

This block gathers interrupt requests from a configurable number of peripheral sources, up to 64. A peripheral sets its source's request flag by pulsing a set line. The flag then stays set until software clears it. Each source also has an enable bit and a 3-bit priority. In every cycle the block picks one winner among the sources that are both enabled and pending. The highest programmed priority wins. When priorities are equal, the lowest source index wins.

The winner's vector number and level are registered into a status word and shown to the CPU. An interrupt request is raised only when that level is strictly above the current CPU priority level. When the CPU acknowledges, the block stores the old CPU level on a small internal stack. It then raises the CPU level to the winner's priority, or to 7 when nesting is disabled. On a return pulse the stored level is restored.

Software accesses flags, enables, priorities, the CPU level, the nesting control and the status word through a word-wide register port. Writes take effect at the clock edge. Reads are combinational.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A high `src_set[i]` sets flag i at the clock edge. The flag stays set until a register write to a flag word (address 0 for sources 0..31, address 1 for sources 32..63, bit i mod 32) with a 1 in that bit position. A set and a clear in the same cycle leave the flag set. Reads of addresses 0 and 1 return the flags.
- R2: Enable bits sit at address 2 (sources 0..31) and address 3 (sources 32..63), one bit per source. A source whose enable bit is clear never wins arbitration, whatever its flag or priority.
- R3: Priorities are packed eight per word. Word 4+k holds sources 8k..8k+7. Source 8k+j occupies bits [4j+2:4j], and the other bits read as zero.
- R4: Among enabled, pending sources the one with the highest priority wins. On equal priority the lowest source index wins.
- R5: The status word at address 14 holds the vector in bits [6:0], the level in bits [11:8] and a valid bit in bit 31. The vector is the source index plus 8. The level is the winner's priority with bit 3 zero. The word is all zero when no source is enabled and pending. The status word and outputs `irq_vec`/`irq_lvl` update one clock edge after the flags, enables or priorities they depend on.
- R6: `irq_req` is high exactly when the status is valid and its level is strictly greater than the CPU level. A winner of priority 0 therefore never requests.
- R7: The CPU level is read and written at address 12. A write replaces bits [2:0] only. Bit 3 cannot be changed by software and resets to 0.
- R8: When `irq_ack` is high while `irq_req` is high and `irq_ret` is low, the old CPU level is pushed on the stack. The CPU level becomes the status level, or 7 if the nesting-disable bit (address 13, bit 0) is set. An acknowledge wins over a same-cycle software write of the CPU level. `irq_ack` has no effect while `irq_req` is low.
- R9: A pulse on `irq_ret` pops the stack into the CPU level. It takes precedence over a same-cycle acknowledge. With an empty stack it leaves the CPU level unchanged.
- R10: An acknowledge does not clear any flag. A flag set again while its source is in service stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_set | input | NUM_SRC | Per-source flag set pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 7 | Vector number of the current winner |
| irq_lvl | output | 4 | Priority level of the current winner |
| irq_ack | input | 1 | CPU acknowledge pulse |
| irq_ret | input | 1 | CPU return-from-interrupt pulse |
| cpu_lvl | output | 4 | Current CPU priority level |

## Verification
Several properties are checked by assertions on every cycle:
- flags never drop without a clearing write;
- a valid winner was enabled and pending in the previous cycle;
- no request is raised at level 0;
- bit 3 of the CPU level survives software writes;
- an acknowledge lands on the expected level;
- a return on an empty stack leaves the level alone;
- the level stack never overflows.

Other behaviours only show in the bench's scenarios, which compare every port on every cycle against a behavioural model. These are:
- the correctness of the winner choice under ties and disabled high-priority sources;
- the exact one-edge latency of the status word;
- level restoration across two nested interrupts;
- the set-wins-over-clear race during service.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int MAX_SRC  = 64;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 4;
    localparam int PRIO_W   = 3;
    localparam int LVL_W    = 4;
    localparam int VEC_W    = 7;
    localparam int VEC_BASE = 8;
    localparam int PRIO_PER_WORD = 8;
    localparam int PRIO_STRIDE   = 4;

    localparam logic [ADDR_W-1:0] A_FLAG0 = 4'd0;
    localparam logic [ADDR_W-1:0] A_FLAG1 = 4'd1;
    localparam logic [ADDR_W-1:0] A_EN0   = 4'd2;
    localparam logic [ADDR_W-1:0] A_EN1   = 4'd3;
    localparam logic [ADDR_W-1:0] A_PRIO0 = 4'd4;
    localparam logic [ADDR_W-1:0] A_CPU   = 4'd12;
    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd13;
    localparam logic [ADDR_W-1:0] A_STAT  = 4'd14;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] vec;
        logic [LVL_W-1:0] lvl;
    } irq_status_t;
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int N  = 16,
    parameter int PW = 3,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    cand,
    input  logic [N*PW-1:0] prio,
    output logic            found,
    output logic [IDX_W-1:0] win_idx,
    output logic [PW-1:0]   win_prio
);
    // Linear scan: a later source replaces the best only when strictly higher,
    // so equal priorities resolve to the lowest index.
    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || prio[i*PW +: PW] > win_prio)) begin
                found    = 1'b1;
                win_idx  = IDX_W'(i);
                win_prio = prio[i*PW +: PW];
            end
        end
    end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top,
    output logic         empty
);
    logic [W-1:0]     mem_d [DEPTH];
    logic [W-1:0]     mem_q [DEPTH];
    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign empty = (cnt_q == '0);
    assign top   = empty ? '0 : mem_q[IDX_W'(cnt_q - 1'b1)];

    always_comb begin
        mem_d = mem_q;
        cnt_d = cnt_q;
        if (pop && !empty) begin
            cnt_d = cnt_q - 1'b1;
        end else if (push && cnt_q != CNT_W'(DEPTH)) begin
            mem_d[IDX_W'(cnt_q)] = din;
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            cnt_q <= cnt_d;
            mem_q <= mem_d;
        end
    end

    // R9
    stack_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt_q != CNT_W'(DEPTH)));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_SRC     = 16,
    parameter int STACK_DEPTH = 8,
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_set,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec,
    output logic [LVL_W-1:0]   irq_lvl,
    input  logic               irq_ack,
    input  logic               irq_ret,
    output logic [LVL_W-1:0]   cpu_lvl
);
    typedef struct packed {
        logic [NUM_SRC-1:0]        flag;
        logic [NUM_SRC-1:0]        en;
        logic [NUM_SRC*PRIO_W-1:0] prio;
        logic [LVL_W-1:0]          cpu;
        logic                      nest_dis;
        irq_status_t               st;
    } state_t;

    state_t s_d, s_q;

    logic [NUM_SRC-1:0] cand;
    logic [NUM_SRC-1:0] clr;
    logic               found;
    logic [IDX_W-1:0]   win_idx;
    logic [PRIO_W-1:0]  win_prio;
    logic               take_ack, take_ret, stk_empty;
    logic [LVL_W-1:0]   stk_top;

    assign cand = s_q.flag & s_q.en;

    irq_arbiter #(.N(NUM_SRC), .PW(PRIO_W)) u_arb (
        .cand     (cand),
        .prio     (s_q.prio),
        .found    (found),
        .win_idx  (win_idx),
        .win_prio (win_prio)
    );

    irq_lvl_stack #(.DEPTH(STACK_DEPTH), .W(LVL_W)) u_stk (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (take_ack),
        .pop   (take_ret),
        .din   (s_q.cpu),
        .top   (stk_top),
        .empty (stk_empty)
    );

    assign irq_req  = s_q.st.valid && (s_q.st.lvl > s_q.cpu);
    assign take_ret = irq_ret && !stk_empty;
    assign take_ack = irq_ack && irq_req && !irq_ret;
    assign irq_vec  = s_q.st.vec;
    assign irq_lvl  = s_q.st.lvl;
    assign cpu_lvl  = s_q.cpu;

    // Write-one-to-clear mask for the flag words
    always_comb begin
        logic [2*DATA_W-1:0] clr_w;
        clr_w = '0;
        if (reg_wr && reg_addr == A_FLAG0) clr_w[DATA_W-1:0] = reg_wdata;
        if (reg_wr && reg_addr == A_FLAG1) clr_w[2*DATA_W-1:DATA_W] = reg_wdata;
        clr = clr_w[NUM_SRC-1:0];
    end

    always_comb begin
        logic [2*DATA_W-1:0] en_w;
        s_d  = s_q;
        en_w = (2*DATA_W)'(s_q.en);

        s_d.flag = (s_q.flag & ~clr) | src_set;

        if (reg_wr && reg_addr == A_EN0) en_w[DATA_W-1:0] = reg_wdata;
        if (reg_wr && reg_addr == A_EN1) en_w[2*DATA_W-1:DATA_W] = reg_wdata;
        s_d.en = en_w[NUM_SRC-1:0];

        for (int i = 0; i < NUM_SRC; i++) begin
            if (reg_wr && reg_addr == A_PRIO0 + ADDR_W'(i / PRIO_PER_WORD))
                s_d.prio[i*PRIO_W +: PRIO_W] =
                    reg_wdata[(i % PRIO_PER_WORD)*PRIO_STRIDE +: PRIO_W];
        end

        if (reg_wr && reg_addr == A_CTRL) s_d.nest_dis = reg_wdata[0];
        if (reg_wr && reg_addr == A_CPU)
            s_d.cpu = {s_q.cpu[LVL_W-1], reg_wdata[LVL_W-2:0]};

        if (take_ret)
            s_d.cpu = stk_top;
        else if (take_ack)
            s_d.cpu = s_q.nest_dis ? LVL_W'(7) : s_q.st.lvl;

        s_d.st.valid = found;
        s_d.st.vec   = found ? VEC_W'(win_idx) + VEC_W'(VEC_BASE) : '0;
        s_d.st.lvl   = found ? {1'b0, win_prio} : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Register read mux
    always_comb begin
        logic [2*DATA_W-1:0] fl_w, en_r;
        fl_w      = (2*DATA_W)'(s_q.flag);
        en_r      = (2*DATA_W)'(s_q.en);
        reg_rdata = '0;
        case (reg_addr)
            A_FLAG0: reg_rdata = fl_w[DATA_W-1:0];
            A_FLAG1: reg_rdata = fl_w[2*DATA_W-1:DATA_W];
            A_EN0:   reg_rdata = en_r[DATA_W-1:0];
            A_EN1:   reg_rdata = en_r[2*DATA_W-1:DATA_W];
            A_CPU:   reg_rdata = DATA_W'(s_q.cpu);
            A_CTRL:  reg_rdata = DATA_W'(s_q.nest_dis);
            A_STAT:  reg_rdata = {s_q.st.valid, 19'b0, s_q.st.lvl, 1'b0, s_q.st.vec};
            default: reg_rdata = '0;
        endcase
        for (int i = 0; i < NUM_SRC; i++) begin
            if (reg_addr == A_PRIO0 + ADDR_W'(i / PRIO_PER_WORD))
                reg_rdata[(i % PRIO_PER_WORD)*PRIO_STRIDE +: PRIO_W] =
                    s_q.prio[i*PRIO_W +: PRIO_W];
        end
    end

    // ---------------- assertions ----------------
    logic [2*DATA_W-1:0] cand_prev_q;
    logic [VEC_W-1:0]    win_off;
    always_ff @(posedge clk) begin
        if (!rst_n) cand_prev_q <= '0;
        else        cand_prev_q <= (2*DATA_W)'(cand);
    end
    assign win_off = s_q.st.vec - VEC_W'(VEC_BASE);

    // R1
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(s_q.flag) & ~$past(clr) & ~s_q.flag) == '0));

    // R2
    win_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.st.valid |-> cand_prev_q[win_off[5:0]]);

    // R6
    no_zero_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_lvl != '0));

    // R7
    cpu_top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CPU) |=> (cpu_lvl[LVL_W-1] == $past(cpu_lvl[LVL_W-1])));

    // R8
    ack_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req && !irq_ret) |=>
            (cpu_lvl == ($past(s_q.nest_dis) ? LVL_W'(7) : $past(irq_lvl))));

    // R9
    ret_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && stk_empty && !(reg_wr && reg_addr == A_CPU)) |=> $stable(cpu_lvl));
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC       = 16;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NSRC-1:0] src_set;
    logic            reg_wr;
    logic [3:0]      reg_addr;
    logic [31:0]     reg_wdata;
    logic [31:0]     reg_rdata;
    logic            irq_req;
    logic [6:0]      irq_vec;
    logic [3:0]      irq_lvl;
    logic            irq_ack;
    logic            irq_ret;
    logic [3:0]      cpu_lvl;

    prio_irq_ctrl #(.NUM_SRC(NSRC), .STACK_DEPTH(8)) i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_set(src_set), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl),
        .irq_ack(irq_ack), .irq_ret(irq_ret), .cpu_lvl(cpu_lvl)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural reference model
    bit m_flag [NSRC];
    bit m_en   [NSRC];
    int m_prio [NSRC];
    int m_cpu, m_vec, m_lvl;
    bit m_nest, m_val;
    int m_stk [$];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSRC; i++) begin
                m_flag[i] = 0; m_en[i] = 0; m_prio[i] = 0;
            end
            m_cpu = 0; m_nest = 0; m_val = 0; m_vec = 0; m_lvl = 0;
            m_stk.delete();
        end else begin
            bit req, bv, old_nest;
            int bi, bp, old_lvl;
            req = m_val && (m_lvl > m_cpu);
            old_nest = m_nest;
            old_lvl = m_lvl;
            bv = 0; bi = 0; bp = 0;
            for (int i = 0; i < NSRC; i++)
                if (m_flag[i] && m_en[i] && (!bv || m_prio[i] > bp)) begin
                    bv = 1; bi = i; bp = m_prio[i];
                end
            if (reg_wr && reg_addr == 12) m_cpu = (m_cpu & 8) | (reg_wdata & 7);
            if (reg_wr && reg_addr == 13) m_nest = reg_wdata[0];
            if (irq_ret) begin
                if (m_stk.size() > 0) m_cpu = m_stk.pop_back();
            end else if (irq_ack && req) begin
                m_stk.push_back(m_cpu);
                m_cpu = old_nest ? 7 : old_lvl;
            end
            for (int i = 0; i < NSRC; i++) begin
                if (reg_wr && reg_addr == 0 && reg_wdata[i]) m_flag[i] = 0;
                if (src_set[i]) m_flag[i] = 1;
                if (reg_wr && reg_addr == 2) m_en[i] = reg_wdata[i];
                if (reg_wr && reg_addr == 4 + i/8) m_prio[i] = (reg_wdata >> ((i%8)*4)) & 7;
            end
            m_val = bv;
            m_vec = bv ? bi + 8 : 0;
            m_lvl = bv ? bp : 0;
        end
    end

    function automatic logic [31:0] m_read(int a);
        logic [31:0] r = '0;
        if (a == 0) for (int i = 0; i < NSRC; i++) r[i] = m_flag[i];
        if (a == 2) for (int i = 0; i < NSRC; i++) r[i] = m_en[i];
        if (a >= 4 && a <= 11)
            for (int i = 0; i < NSRC; i++)
                if (4 + i/8 == a) r[(i%8)*4 +: 3] = 3'(m_prio[i]);
        if (a == 12) r = 32'(m_cpu);
        if (a == 13) r = 32'(m_nest);
        if (a == 14) r = {m_val, 19'b0, 4'(m_lvl), 1'b0, 7'(m_vec)};
        return r;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // compare every cycle, a quarter period after the rising edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n && !finished) begin
            bit exp_req;
            string rtag;
            exp_req = m_val && (m_lvl > m_cpu);
            chk("R6 irq_req", 32'(irq_req), 32'(exp_req));
            chk("R4 R5 irq_vec", 32'(irq_vec), 32'(m_vec));
            chk("R5 irq_lvl", 32'(irq_lvl), 32'(m_lvl));
            chk("R7 R8 R9 cpu_lvl", 32'(cpu_lvl), 32'(m_cpu));
            if (reg_addr <= 1)       rtag = "R1 R10 flag read";
            else if (reg_addr <= 3)  rtag = "R2 enable read";
            else if (reg_addr <= 11) rtag = "R3 priority read";
            else if (reg_addr == 12) rtag = "R7 cpu level read";
            else if (reg_addr == 13) rtag = "R8 nest control read";
            else                     rtag = "R5 status read";
            chk(rtag, reg_rdata, m_read(int'(reg_addr)));
        end
    end

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = 4'(a); reg_wdata = d;
        @(negedge clk); reg_wr = 0; reg_addr = 4'd14;
    endtask
    task automatic pulse(logic [NSRC-1:0] m);
        @(negedge clk); src_set = m;
        @(negedge clk); src_set = '0;
    endtask
    task automatic ack();
        @(negedge clk); irq_ack = 1;
        @(negedge clk); irq_ack = 0;
    endtask
    task automatic ret();
        @(negedge clk); irq_ret = 1;
        @(negedge clk); irq_ret = 0;
    endtask
    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic sweep();
        for (int a = 0; a < 15; a++) begin
            @(negedge clk); reg_addr = 4'(a);
        end
        @(negedge clk); reg_addr = 4'd14;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; src_set = '0; reg_wr = 0; reg_addr = 4'd14; reg_wdata = '0;
        irq_ack = 0; irq_ret = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        sweep();                                // reset state of every register
        wr(2, 32'h0000_FF7F);                   // R2: source 7 left disabled
        wr(4, 32'h7040_2000);                   // R3: src3=2, src5=4, src7=7
        wr(5, 32'h0006_0040);                   // R3: src9=4, src12=6
        pulse(16'h0001); idle(3);               // R6: priority 0 never requests
        wr(0, 32'h1);                           // R1: clear flag 0
        pulse(16'h0008); idle(2);               // R5: vector 11, level 2
        ack(); idle(2);                         // R8: cpu to 2
        ack(); idle(1);                         // R8: ignored, no request
        pulse(16'h1000); idle(2);               // R4: src12 preempts
        ack(); idle(1);                         // R8: nested, cpu to 6
        wr(0, 32'h1008);                        // R1: clear 3 and 12
        ret(); idle(1); ret(); idle(1);         // R9: back to 2, then 0
        ret(); idle(1);                         // R9: empty stack
        pulse(16'h0220); idle(2);               // R4: tie 5 and 9 -> vector 13
        pulse(16'h0080); idle(2);               // R2: disabled src7 loses
        sweep();
        wr(13, 32'h1);                          // R8: nesting disabled
        ack(); idle(1);                         // cpu to 7
        pulse(16'h1000); idle(2);               // no preemption at level 7
        wr(12, 32'hF); idle(1);                 // R7: bit 3 stays 0
        ret(); idle(1);
        wr(13, 32'h0); idle(1);
        ack(); idle(1);                         // R10: serve src12 at 6
        @(negedge clk); reg_wr = 1; reg_addr = 4'd0; reg_wdata = 32'h1000; src_set = 16'h1000;
        @(negedge clk); reg_wr = 0; reg_addr = 4'd0; src_set = '0;
        idle(2);                                // R1 R10: flag 12 still set
        wr(12, 32'h3); idle(2);                 // R7: write level while nested
        @(negedge clk); irq_ack = 1; irq_ret = 1;   // R9: return wins over ack
        @(negedge clk); irq_ack = 0; irq_ret = 0;
        idle(2);
        wr(0, 32'hFFFF); idle(3);
        sweep();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule